// File: doc/BRIEF.md
# Interrupt Redirection Dispatcher

This block collects interrupt requests from a set of input lines, records them in a pending vector, and turns each pending, unmasked pin into one delivery message. The message fields come from that pin's 64-bit redirection entry, which sits in a table outside the block. The block reads the table through a single indexed read port. Pins are either edge-triggered or level-triggered, and the two kinds keep their pending bits in different ways. A pin whose entry selects the external-interrupt delivery mode does not use the vector stored in its entry. The block instead fetches the vector from a legacy interrupt controller through a request/acknowledge handshake.

A service pass visits the pins from lowest to highest, one pin per cycle. A pass starts when a request is asserted, and also when the surrounding register logic reports a write to the table. Messages leave on a valid/ready channel. The scan waits while a message is offered and not yet taken. If a new trigger arrives during a pass, one further pass is run after the current one ends.

Top module: `irq_redirect_dispatch`

## Requirements
- R1: After reset, no message is offered, no vector fetch is requested and no pin is pending.
- R2: A pin whose entry has bit 16 set is never delivered. An edge request that arrives on a masked pin stays pending, and it is delivered by the pass that follows the write which clears bit 16.
- R3: The message carries the destination from entry bits 63:56, the destination mode from bit 11, the delivery mode from bits 10:8, the polarity from bit 13, the trigger mode from bit 15 and the vector from bits 7:0.
- R4: A level pin is one whose entry bit 15 is 1. It is pending exactly while its request is high. It is delivered once in every pass during which it is pending. After the request drops, no later pass delivers it.
- R5: An edge pin is one whose entry bit 15 is 0. Its pending bit is set by a rising transition of its request and cleared when its message is accepted. A request held high does not set the bit again.
- R6: When the delivery mode field equals 7, the block raises the fetch request and holds it until it is acknowledged. The message vector is then the legacy controller's value captured at the acknowledge.
- R7: A request on input 0 is steered to pin 2. All other inputs drive the pin with the same number.
- R8: Within one pass, messages leave in ascending pin order.
- R9: A table-write pulse starts a service pass. A rising edge on any request also starts one.
- R10: While the message is offered and not accepted, it stays offered and none of its fields change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NPINS | Request inputs, synchronous to clk |
| pin_level_mode | input | NPINS | Bit 15 of every pin's entry (1 = level) |
| tbl_wr | input | 1 | Pulse: a table entry was written |
| tbl_idx | output | IDXW | Table read index |
| tbl_entry | input | 64 | Entry at tbl_idx, same cycle |
| dv_valid | output | 1 | Message offered |
| dv_ready | input | 1 | Message accepted |
| dv_dest | output | 8 | Destination |
| dv_dest_mode | output | 1 | Destination mode |
| dv_mode | output | 3 | Delivery mode |
| dv_vector | output | 8 | Vector |
| dv_polarity | output | 1 | Polarity |
| dv_trigger | output | 1 | Trigger mode (1 = level) |
| lv_req | output | 1 | Legacy vector fetch request |
| lv_ack | input | 1 | Legacy vector acknowledge |
| lv_vector | input | 8 | Legacy vector, valid with lv_ack |

## Verification
A pending bit that is wrong stays hidden until the next pass reaches that pin. If an edge bit fails to clear, the next table-write pulse produces a duplicate message within about one scan length, NPINS cycles. If a level bit stays set after its request drops, it shows up the same way. A bad scan pointer shows up at once as messages out of pin order or with fields from the wrong entry. A broken fetch path shows up as a message carrying the entry's own vector where the legacy value belongs.

// File: rtl/irq_redirect_dispatch.sv
module irq_redirect_dispatch #(
  parameter int NPINS       = 24,
  parameter int EXTINT_MODE = 7,
  parameter int IDXW        = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] irq_in,
  input  logic [NPINS-1:0] pin_level_mode,
  input  logic             tbl_wr,
  output logic [IDXW-1:0]  tbl_idx,
  input  logic [63:0]      tbl_entry,
  output logic             dv_valid,
  input  logic             dv_ready,
  output logic [7:0]       dv_dest,
  output logic             dv_dest_mode,
  output logic [2:0]       dv_mode,
  output logic [7:0]       dv_vector,
  output logic             dv_polarity,
  output logic             dv_trigger,
  output logic             lv_req,
  input  logic             lv_ack,
  input  logic [7:0]       lv_vector
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FETCH, S_SEND} st_t;

  st_t              st;
  logic [IDXW-1:0]  ptr;
  logic             rerun;
  logic [NPINS-1:0] pend, req_q, pinreq, rise, clr;
  logic             unused_bits;

  assign unused_bits = ^{tbl_entry[55:17], tbl_entry[14], tbl_entry[12]};

  always_comb begin
    pinreq    = irq_in;
    pinreq[0] = 1'b0;
    pinreq[2] = irq_in[0] | irq_in[2];
  end

  assign rise = pinreq & ~req_q;

  logic start, hit, last, xfer, advance;
  assign start   = (|rise) | tbl_wr;
  assign hit     = pend[ptr] && !tbl_entry[16];
  assign last    = ptr == IDXW'(NPINS - 1);
  assign dv_valid = st == S_SEND;
  assign lv_req  = st == S_FETCH;
  assign xfer    = dv_valid && dv_ready;
  assign advance = (st == S_SCAN && !hit) || xfer;
  assign clr     = xfer ? (NPINS'(1) << ptr) : '0;
  assign tbl_idx = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= pinreq;
      pend  <= (pin_level_mode & pinreq) | (~pin_level_mode & ((pend & ~clr) | rise));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      ptr          <= '0;
      rerun        <= 1'b0;
      dv_dest      <= '0;
      dv_dest_mode <= 1'b0;
      dv_mode      <= '0;
      dv_vector    <= '0;
      dv_polarity  <= 1'b0;
      dv_trigger   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st  <= S_SCAN;
          ptr <= '0;
        end
        S_SCAN: if (hit) begin
          dv_dest      <= tbl_entry[63:56];
          dv_dest_mode <= tbl_entry[11];
          dv_mode      <= tbl_entry[10:8];
          dv_vector    <= tbl_entry[7:0];
          dv_polarity  <= tbl_entry[13];
          dv_trigger   <= tbl_entry[15];
          st <= (tbl_entry[10:8] == 3'(EXTINT_MODE)) ? S_FETCH : S_SEND;
        end
        S_FETCH: if (lv_ack) begin
          dv_vector <= lv_vector;
          st        <= S_SEND;
        end
        default: ;
      endcase
      if (advance) begin
        if (last) begin
          ptr <= '0;
          st  <= (rerun || start) ? S_SCAN : S_IDLE;
        end else begin
          ptr <= ptr + IDXW'(1);
          st  <= S_SCAN;
        end
      end
      if (st != S_IDLE) begin
        if (advance && last) rerun <= 1'b0;
        else if (start)      rerun <= 1'b1;
      end
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dv_valid && !dv_ready |=> dv_valid &&
      $stable({dv_dest, dv_dest_mode, dv_mode, dv_vector, dv_polarity, dv_trigger}));

  assert_fetch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lv_req && !lv_ack |=> lv_req);

  assert_masked_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SCAN && tbl_entry[16] |=> !dv_valid && !lv_req);

  assert_edge_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !pin_level_mode[ptr] && !rise[ptr] |=> !pend[$past(ptr)]);

  assert_remap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in[0] && !req_q[2] && !pin_level_mode[2] |=> pend[2]);

  assert_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !last |=> ptr > $past(ptr));
endmodule

// File: tb/irq_redirect_dispatch_test.sv
module irq_redirect_dispatch_test;
  localparam int N = 24;
  localparam int W = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0, lvl;
  logic tbl_wr = 0;
  logic [W-1:0] tbl_idx;
  logic [63:0] tbl_entry;
  logic dv_valid, dv_ready = 1, dv_dest_mode, dv_polarity, dv_trigger, lv_req;
  logic [7:0] dv_dest, dv_vector;
  logic [2:0] dv_mode;
  logic lv_ack = 0;
  logic [7:0] lv_vector = 0, legacy_val = 8'h99;
  logic [63:0] tbl [N];
  logic [21:0] expq[$];
  int total = 0, bad = 0, fetches = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign tbl_entry = tbl[tbl_idx];
  always_comb for (int i = 0; i < N; i++) lvl[i] = tbl[i][15];

  irq_redirect_dispatch uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pin_level_mode(lvl), .tbl_wr(tbl_wr),
    .tbl_idx(tbl_idx), .tbl_entry(tbl_entry), .dv_valid(dv_valid), .dv_ready(dv_ready),
    .dv_dest(dv_dest), .dv_dest_mode(dv_dest_mode), .dv_mode(dv_mode), .dv_vector(dv_vector),
    .dv_polarity(dv_polarity), .dv_trigger(dv_trigger), .lv_req(lv_req), .lv_ack(lv_ack),
    .lv_vector(lv_vector));

  function automatic logic [63:0] mk(logic [7:0] d, logic dm, logic [2:0] m, logic [7:0] v,
                                     logic p, logic t, logic msk);
    logic [63:0] e = '0;
    e[63:56] = d; e[16] = msk; e[15] = t; e[13] = p; e[11] = dm; e[10:8] = m; e[7:0] = v;
    return e;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic expect_msg(logic [7:0] d, logic dm, logic [2:0] m, logic [7:0] v, logic p, logic t);
    expq.push_back({d, dm, m, v, p, t});
  endtask

  task automatic step(int n); repeat (n) @(posedge clk); #1; endtask

  task automatic wr(int pin, logic [63:0] e);
    step(1); tbl[pin] = e; tbl_wr = 1; step(1); tbl_wr = 0;
  endtask

  task automatic pulse(logic [N-1:0] m);
    step(1); irq_in = irq_in | m; step(2); irq_in = irq_in & ~m;
  endtask

  task automatic drain(string req);
    step(70);
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  always @(negedge clk) if (rst_n && dv_valid && dv_ready) begin
    logic [21:0] got;
    got = {dv_dest, dv_dest_mode, dv_mode, dv_vector, dv_polarity, dv_trigger};
    if (expq.size() == 0) check(0, "R2/R4/R5 unexpected message", got, 0);
    else begin
      logic [21:0] e;
      e = expq.pop_front();
      check(got == e, "R3/R8 message fields", got, e);
    end
  end

  initial forever begin
    @(negedge clk);
    if (lv_req && !lv_ack) begin
      fetches++;
      step(1); lv_ack = 1; lv_vector = legacy_val;
      step(1); lv_ack = 0;
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) tbl[i] = 64'h1_0000;
    step(3);
    check(dv_valid == 0, "R1 valid", dv_valid, 0);
    check(lv_req == 0, "R1 fetch", lv_req, 0);
    rst_n = 1;
    wr(1, 64'h1_0000);
    drain("R1 no pending after reset");

    // R3 R5 edge pin
    wr(5, mk(8'h12, 1, 3'd0, 8'h35, 1, 0, 0));
    drain("R9 empty pass");
    expect_msg(8'h12, 1, 3'd0, 8'h35, 1, 0);
    pulse(1 << 5);
    drain("R5 edge delivery");
    wr(1, 64'h1_0000);
    drain("R5 pending cleared");

    // R2 masked pin held pending
    tbl[6] = mk(8'h06, 0, 3'd0, 8'h36, 0, 0, 1);
    pulse(1 << 6);
    drain("R2 masked");
    expect_msg(8'h06, 0, 3'd0, 8'h36, 0, 0);
    wr(6, mk(8'h06, 0, 3'd0, 8'h36, 0, 0, 0));
    drain("R2 unmask delivers");

    // R8 ascending order
    wr(20, mk(8'h20, 0, 3'd1, 8'h54, 0, 0, 0));
    wr(9,  mk(8'h09, 1, 3'd0, 8'h49, 0, 0, 0));
    wr(3,  mk(8'h03, 0, 3'd2, 8'h43, 1, 0, 0));
    drain("R9 empty passes");
    expect_msg(8'h03, 0, 3'd2, 8'h43, 1, 0);
    expect_msg(8'h09, 1, 3'd0, 8'h49, 0, 0);
    expect_msg(8'h20, 0, 3'd1, 8'h54, 0, 0);
    pulse((1 << 20) | (1 << 9) | (1 << 3));
    drain("R8 order");

    // R4 level pin
    wr(7, mk(8'h77, 0, 3'd1, 8'h47, 0, 1, 0));
    drain("R4 idle level");
    expect_msg(8'h77, 0, 3'd1, 8'h47, 0, 1);
    step(1); irq_in[7] = 1;
    drain("R4 level first pass");
    expect_msg(8'h77, 0, 3'd1, 8'h47, 0, 1);
    wr(1, 64'h1_0000);
    drain("R4 level repeats on R9 pass");
    step(1); irq_in[7] = 0;
    step(3);
    wr(1, 64'h1_0000);
    drain("R4 level cleared on drop");

    // R7 remap
    tbl[0] = mk(8'h00, 0, 3'd0, 8'h10, 0, 0, 0);
    wr(2, mk(8'h02, 0, 3'd0, 8'h22, 0, 0, 0));
    expect_msg(8'h02, 0, 3'd0, 8'h22, 0, 0);
    pulse(1 << 0);
    drain("R7 remap");

    // R6 external interrupt vector
    wr(4, mk(8'h44, 0, 3'd7, 8'h44, 0, 0, 0));
    fetches = 0;
    expect_msg(8'h44, 0, 3'd7, 8'h99, 0, 0);
    pulse(1 << 4);
    drain("R6 legacy vector");
    check(fetches == 1, "R6 fetch count", fetches, 1);

    // R5 held high no retrigger
    wr(12, mk(8'h0C, 1, 3'd0, 8'h5C, 1, 0, 0));
    expect_msg(8'h0C, 1, 3'd0, 8'h5C, 1, 0);
    step(1); irq_in[12] = 1;
    drain("R5 held edge first");
    wr(1, 64'h1_0000);
    drain("R5 held edge no retrigger");
    step(1); irq_in[12] = 0;

    // R10 stall
    wr(11, mk(8'h0B, 0, 3'd3, 8'h5B, 0, 0, 0));
    step(1); dv_ready = 0;
    expect_msg(8'h0B, 0, 3'd3, 8'h5B, 0, 0);
    pulse(1 << 11);
    step(40);
    check(dv_valid == 1, "R10 held offer", dv_valid, 1);
    check(expq.size() == 1, "R10 not taken", expq.size(), 1);
    dv_ready = 1;
    drain("R10 delivered once");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule